// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit I/O virtual address into a 32-bit physical address by reading two entries from tables held in memory. A software-written base register gives the location of the root directory. For each accepted request the block reads one directory word. If that word is valid, it reads one page word from the second-level table the directory word points to. It then reports the physical address together with the 4-bit access control index stored in the page word.

A directory word that is not valid ends the walk with a level-one fault. A page word that is not valid ends it with a level-two fault. Each fault kind copies the faulting virtual address into its own error-address register. Only one walk runs at a time. The block keeps no copy of any entry, so every translation goes to memory.

The controller has five states. In IDLE, `req_ready` is high. A handshake moves it to DIR_ISSUE. DIR_ISSUE sends the directory read for one cycle and always goes on to DIR_WAIT. In DIR_WAIT, a response carrying a valid directory word leads to PTE_ISSUE, and a response carrying an invalid word returns to IDLE with a level-one fault. PTE_ISSUE sends the page read and always goes on to PTE_WAIT. In PTE_WAIT, any response returns to IDLE, either with a result or with a level-two fault.

Top module: `iova_walker`

## Requirements
- R1: After reset the outputs are as follows. `req_ready`=1. `busy`=0. `mem_req`=0. `rsp_valid`=0. Both error-address registers read 0. The base register holds 0.
- R2: In the cycle after a request handshake, `mem_req` is high for exactly one cycle. In that cycle `mem_addr` equals the base with bits 13:0 forced to zero, plus 4 × virtual address bits 31:20.
- R3: A directory word is valid only when bits 1:0 equal 2'b01. For any other value, `rsp_valid` is high in the same cycle as `mem_rvalid`, with `rsp_fault`=1 (level one). No further `mem_req` follows.
- R4: After a valid directory word, a one-cycle `mem_req` follows in the next cycle. Its address is the directory word with bits 9:0 cleared, plus 4 × virtual address bits 19:12.
- R5: A page word is valid only when bit 1 is set. For an invalid page word, `rsp_valid` is high in the same cycle as `mem_rvalid`, with `rsp_fault`=2 (level two).
- R6: For a valid page word, `rsp_fault`=0. `rsp_paddr` = {page word bits 31:12, virtual address bits 11:0}. `rsp_aci` = page word bits 7:4. Page word bits 11:8, 3:2 and 0 have no effect.
- R7: On a level-one fault, `l1_err_addr` takes the faulting virtual address from the next cycle on. A level-two fault does the same for `l2_err_addr`. The other register keeps its value.
- R8: While a walk is active, `busy`=1 and `req_ready`=0. Requests presented in that time are not taken and do not change the walk in progress.
- R9: Any number of wait cycles may pass between a read and its response. `mem_req` stays low while waiting, and the result does not depend on the wait.
- R10: Writes to the base register ignore bits 13:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | Directory base value (bits 13:0 dropped) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 2 | 0 result, 1 level-one fault, 2 level-two fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_aci | output | 4 | Access control index (0 on fault) |
| l1_err_addr | output | 32 | Last level-one faulting address |
| l2_err_addr | output | 32 | Last level-two faulting address |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |

## Verification
The directory read strobe is due exactly one cycle after the request handshake. The page read strobe is due one cycle after a valid directory response. The result or fault is due in the same cycle as the response that decides it, and the error-address registers change one cycle after that. The bench drives every input on the falling edge. It then checks each of these outputs in the exact cycle its timing predicts, and checks that `mem_req` stays low during each inserted wait cycle. A walk ends only when the bench sends the deciding response, so the cycle at which each result appears is known in advance.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DIR_ISSUE = 3'd1,
        ST_DIR_WAIT  = 3'd2,
        ST_PTE_ISSUE = 3'd3,
        ST_PTE_WAIT  = 3'd4
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_PTE  = 2'd2
    } walk_fault_e;

    localparam logic [1:0] DIR_VALID_CODE = 2'b01;

endpackage

// File: rtl/walk_entry_dec.sv
module walk_entry_dec #(
    parameter int AW        = 32,
    parameter int PT_ALIGN  = 10,
    parameter int FRAME_LSB = 12,
    parameter int ACI_LSB   = 4,
    parameter int ACI_W     = 4,
    parameter int VALID_BIT = 1
) (
    input  logic [AW-1:0]    entry,
    output logic             dir_ok,
    output logic [AW-1:0]    dir_table,
    output logic             pte_ok,
    output logic [AW-1:0]    pte_frame,
    output logic [ACI_W-1:0] pte_aci
);
    import walk_pkg::*;

    localparam logic [AW-1:0] TABLE_MASK = {AW{1'b1}} << PT_ALIGN;
    localparam logic [AW-1:0] FRAME_MASK = {AW{1'b1}} << FRAME_LSB;

    always_comb begin
        dir_ok    = (entry[1:0] == DIR_VALID_CODE);
        dir_table = entry & TABLE_MASK;
        pte_ok    = entry[VALID_BIT];
        pte_frame = entry & FRAME_MASK;
        pte_aci   = entry[ACI_LSB +: ACI_W];
    end

endmodule

// File: rtl/walk_fsm.sv
module walk_fsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_fire,
    input  logic                     mem_rvalid,
    input  logic                     dir_ok,
    input  logic                     pte_ok,
    output walk_pkg::walk_state_e    state,
    output logic                     req_ready,
    output logic                     busy,
    output logic                     mem_req,
    output logic                     done,
    output walk_pkg::walk_fault_e    fault,
    output logic                     load_table
);
    import walk_pkg::*;

    walk_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_fire) state_d = ST_DIR_ISSUE;
            ST_DIR_ISSUE: state_d = ST_DIR_WAIT;
            ST_DIR_WAIT:  if (mem_rvalid) state_d = dir_ok ? ST_PTE_ISSUE : ST_IDLE;
            ST_PTE_ISSUE: state_d = ST_PTE_WAIT;
            ST_PTE_WAIT:  if (mem_rvalid) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        busy       = 1'b1;
        mem_req    = 1'b0;
        done       = 1'b0;
        fault      = FLT_NONE;
        load_table = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            ST_DIR_ISSUE: mem_req = 1'b1;
            ST_DIR_WAIT: begin
                if (mem_rvalid && dir_ok) load_table = 1'b1;
                if (mem_rvalid && !dir_ok) begin
                    done  = 1'b1;
                    fault = FLT_DIR;
                end
            end
            ST_PTE_ISSUE: mem_req = 1'b1;
            ST_PTE_WAIT: begin
                if (mem_rvalid) begin
                    done  = 1'b1;
                    fault = pte_ok ? FLT_NONE : FLT_PTE;
                end
            end
            default: busy = 1'b0;
        endcase
    end

    assign state = state_q;

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R2
    AST_FAULT_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == FLT_DIR) |=> (!mem_req && !busy)); // R3
    AST_DIR_OK_NEXT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        load_table |=> mem_req); // R4

endmodule

// File: rtl/walk_errlog.sv
module walk_errlog #(
    parameter int AW      = 32,
    parameter int NLEVELS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NLEVELS-1:0]           log_en,
    input  logic [AW-1:0]                vaddr,
    output logic [NLEVELS-1:0][AW-1:0]   err_addr
);
    for (genvar g = 0; g < NLEVELS; g++) begin : g_lvl
        logic [AW-1:0] addr_q;
        always_ff @(posedge clk) begin
            if (!rst_n)         addr_q <= '0;
            else if (log_en[g]) addr_q <= vaddr;
        end
        assign err_addr[g] = addr_q;

        AST_LOG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !log_en[g] |=> $stable(err_addr[g])); // R7
    end

endmodule

// File: rtl/iova_walker.sv
module iova_walker #(
    parameter int AW         = 32,
    parameter int DIR_BITS   = 12,
    parameter int PT_BITS    = 8,
    parameter int OFF_BITS   = 12,
    parameter int ACI_W      = 4,
    parameter int ACI_LSB    = 4,
    parameter int BASE_ALIGN = 14,
    parameter int PT_ALIGN   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic [31:0]      base_wdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    output logic             busy,
    output logic             rsp_valid,
    output logic [1:0]       rsp_fault,
    output logic [31:0]      rsp_paddr,
    output logic [3:0]       rsp_aci,
    output logic [31:0]      l1_err_addr,
    output logic [31:0]      l2_err_addr,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata
);
    import walk_pkg::*;

    localparam int ENTRY_LOG = 2;
    localparam int DIR_LSB   = OFF_BITS + PT_BITS;
    localparam int PT_LSB    = OFF_BITS;
    localparam logic [AW-1:0] BASE_MASK = {AW{1'b1}} << BASE_ALIGN;
    localparam logic [AW-1:0] OFF_MASK  = ~({AW{1'b1}} << OFF_BITS);

    logic [AW-1:0] base_q, vaddr_q, table_q;

    walk_state_e   state;
    walk_fault_e   fault;
    logic          req_fire, done, load_table;
    logic          dir_ok, pte_ok;
    logic [AW-1:0] dir_table, pte_frame;
    logic [ACI_W-1:0] pte_aci;
    logic [AW-1:0] dir_off, pt_off;
    logic [1:0][AW-1:0] err_addr;

    assign req_fire = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            vaddr_q <= '0;
            table_q <= '0;
        end else begin
            if (base_we)    base_q  <= base_wdata & BASE_MASK;
            if (req_fire)   vaddr_q <= req_vaddr;
            if (load_table) table_q <= dir_table;
        end
    end

    walk_entry_dec #(
        .AW(AW), .PT_ALIGN(PT_ALIGN), .FRAME_LSB(OFF_BITS),
        .ACI_LSB(ACI_LSB), .ACI_W(ACI_W), .VALID_BIT(1)
    ) u_dec (
        .entry(mem_rdata), .dir_ok(dir_ok), .dir_table(dir_table),
        .pte_ok(pte_ok), .pte_frame(pte_frame), .pte_aci(pte_aci)
    );

    walk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .mem_rvalid(mem_rvalid),
        .dir_ok(dir_ok), .pte_ok(pte_ok), .state(state), .req_ready(req_ready),
        .busy(busy), .mem_req(mem_req), .done(done), .fault(fault),
        .load_table(load_table)
    );

    walk_errlog #(.AW(AW), .NLEVELS(2)) u_log (
        .clk(clk), .rst_n(rst_n),
        .log_en({done && fault == FLT_PTE, done && fault == FLT_DIR}),
        .vaddr(vaddr_q), .err_addr(err_addr)
    );

    assign dir_off = {{(AW-DIR_BITS-ENTRY_LOG){1'b0}}, vaddr_q[DIR_LSB +: DIR_BITS], {ENTRY_LOG{1'b0}}};
    assign pt_off  = {{(AW-PT_BITS-ENTRY_LOG){1'b0}},  vaddr_q[PT_LSB +: PT_BITS],   {ENTRY_LOG{1'b0}}};

    always_comb begin
        mem_addr = '0;
        if (state == ST_DIR_ISSUE)      mem_addr = base_q + dir_off;
        else if (state == ST_PTE_ISSUE) mem_addr = table_q + pt_off;
    end

    always_comb begin
        rsp_valid = done;
        rsp_fault = fault;
        rsp_paddr = '0;
        rsp_aci   = '0;
        if (done && fault == FLT_NONE) begin
            rsp_paddr = pte_frame | (vaddr_q & OFF_MASK);
            rsp_aci   = pte_aci;
        end
    end

    assign l1_err_addr = err_addr[0];
    assign l2_err_addr = err_addr[1];

    AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> (mem_req && busy)); // R2
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R2
    AST_L1_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd1) |=> l1_err_addr == $past(vaddr_q)); // R7
    AST_RSP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_rvalid && busy)); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rsp_valid)); // R8

endmodule

// File: tb/tb_iova_walker.sv
module tb_iova_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        busy, rsp_valid;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_aci;
    logic [31:0] l1_err_addr, l2_err_addr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] base_m = '0;
    logic [31:0] l1_m = '0;
    logic [31:0] l2_m = '0;

    always #5 clk = ~clk;

    iova_walker dut (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_aci(rsp_aci), .l1_err_addr(l1_err_addr),
        .l2_err_addr(l2_err_addr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] f_dir_addr(logic [31:0] b, logic [31:0] va);
        return {b[31:14], 14'd0} + {18'd0, va[31:20], 2'd0};
    endfunction
    function automatic logic [31:0] f_pte_addr(logic [31:0] d, logic [31:0] va);
        return {d[31:10], 10'd0} + {22'd0, va[19:12], 2'd0};
    endfunction
    function automatic logic [31:0] f_paddr(logic [31:0] p, logic [31:0] va);
        return {p[31:12], va[11:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One full walk; junk requests are presented during waits (R8)
    task automatic walk(input logic [31:0] va, input logic [31:0] dw, input logic [31:0] pw,
                        input int w1, input int w2);
        bit dir_good = (dw[1:0] == 2'b01);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        #1 chk(req_ready == 1'b1, "R8 ready idle", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = ~va;
        #1;
        chk(mem_req == 1'b1, "R2 dir strobe", {31'd0, mem_req}, 32'd1);
        chk(mem_addr == f_dir_addr(base_m, va), "R2 dir address", mem_addr, f_dir_addr(base_m, va));
        chk(busy && !req_ready, "R8 busy", {30'd0, busy, req_ready}, 32'd2);
        for (int k = 0; k < w1; k++) begin
            @(negedge clk); #1;
            chk(mem_req == 1'b0, "R9 dir wait quiet", {31'd0, mem_req}, 32'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = dw;
        #1;
        if (!dir_good) begin
            chk(rsp_valid && rsp_fault == 2'd1, "R3 level-one fault", {30'd0, rsp_fault}, 32'd1);
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = $urandom;
            l1_m = va;
            #1;
            chk(!mem_req && !busy, "R3 no further read", {30'd0, mem_req, busy}, 32'd0);
            chk(l1_err_addr == l1_m, "R7 l1 error address", l1_err_addr, l1_m);
            chk(l2_err_addr == l2_m, "R7 l2 unchanged", l2_err_addr, l2_m);
            return;
        end
        chk(rsp_valid == 1'b0, "R3 valid dir no rsp", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = $urandom;
        #1;
        chk(mem_req == 1'b1, "R4 pte strobe", {31'd0, mem_req}, 32'd1);
        chk(mem_addr == f_pte_addr(dw, va), "R4 pte address", mem_addr, f_pte_addr(dw, va));
        for (int k = 0; k < w2; k++) begin
            @(negedge clk); #1;
            chk(mem_req == 1'b0, "R9 pte wait quiet", {31'd0, mem_req}, 32'd0);
        end
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = pw;
        #1;
        if (pw[1]) begin
            chk(rsp_valid && rsp_fault == 2'd0, "R6 success", {30'd0, rsp_fault}, 32'd0);
            chk(rsp_paddr == f_paddr(pw, va), "R6 paddr", rsp_paddr, f_paddr(pw, va));
            chk(rsp_aci == pw[7:4], "R6 aci", {28'd0, rsp_aci}, {28'd0, pw[7:4]});
        end else begin
            chk(rsp_valid && rsp_fault == 2'd2, "R5 level-two fault", {30'd0, rsp_fault}, 32'd2);
            l2_m = va;
        end
        @(negedge clk);
        mem_rvalid = 1'b0;
        #1;
        chk(!busy && req_ready, "R8 walk done", {30'd0, busy, req_ready}, 32'd1);
        chk(l2_err_addr == l2_m, "R7 l2 error address", l2_err_addr, l2_m);
        chk(l1_err_addr == l1_m, "R7 l1 unchanged", l1_err_addr, l1_m);
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        base_we = 1'b1; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
        base_m = v & 32'hFFFF_C000;
    endtask

    initial begin
        int n = 0;
        while (!finished && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready && !busy && !mem_req && !rsp_valid, "R1 reset outputs",
            {28'd0, req_ready, busy, mem_req, rsp_valid}, 32'd8);
        chk(l1_err_addr == 0 && l2_err_addr == 0, "R1 error registers", l1_err_addr | l2_err_addr, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: base holds 0 after reset
        walk(32'h0030_5ABC, 32'h1234_5401, 32'hABCD_E0F2, 0, 0);
        // R10: low base bits dropped
        set_base(32'h8000_3FFF);
        walk(32'hFFF0_0123, 32'h0000_0403, 32'h0, 2, 0);          // R3 code 11
        walk(32'h1234_5678, 32'h4000_07FD, 32'h0, 0, 0);          // R3 code 01 with reserved bits set
        walk(32'h1234_5678, 32'h4000_0000, 32'h0, 1, 0);          // R3 code 00
        walk(32'h0ABC_DEF0, 32'h0000_0002, 32'h0, 0, 0);          // R3 code 10
        walk(32'h0001_F000, 32'hFFFF_FC01, 32'h5555_5FFD, 0, 3);  // R5 bit1 clear, others set
        walk(32'h0000_0FFF, 32'h0000_0401, 32'h0000_0F0F, 4, 4);  // R6 ignored bits set
        walk(32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'hFFFF_F0F2, 0, 0);  // R6 all-ones corners
        set_base(32'h0000_0000);
        walk(32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 7, 9);  // R9 long waits

        for (int i = 0; i < 400; i++) begin
            logic [31:0] va = $urandom;
            logic [31:0] dw = $urandom;
            logic [31:0] pw = $urandom;
            int r = $urandom_range(0, 9);
            if (r < 7) dw[1:0] = 2'b01;
            if ($urandom_range(0, 9) < 2) set_base($urandom);
            walk(va, dw, pw, $urandom_range(0, 5), $urandom_range(0, 5));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule